// File: doc/BRIEF.md
# DAC Output Range Control Register

This block stores the range settings of a DAC that drives a voltage output, a current output, or both. Three write strobes load it: one for the control word (range code, overrange, clear select, output enable), one for the configuration word (dual-output enable, current-range field) and one for the 16-bit DAC data word. It decodes the stored settings into an enable flag and a span code for each output, together with an overrange-active flag.

Range code 100 is reserved, and a control write that carries it is dropped as a whole. Whenever an accepted control write changes the range code, the data register is loaded with a clear code on the next clock edge. The clear code depends on the new range and the clear-select bit, and it wins over a data write made in the same cycle.

Top module: `dac_range_ctrl`

## Requirements
- R1: After the asynchronous active-low reset:
  - the range code is 000;
  - the overrange, clear-select, output-enable and dual-output bits are 0;
  - the current-range field is 00;
  - data_o is 0x0000;
  - vout_en_o and iout_en_o are low.
- R2: In single-output mode (dual bit 0) the span outputs decode from the range code:
  - Voltage codes set vspan_o as follows: 000 (0–5 V) gives 1, 001 (0–10 V) gives 2, 010 (±5 V) gives 3 and 011 (±10 V) gives 4. Any other code gives vspan_o 0.
  - Current codes set ispan_o as follows: 101 (4–20 mA) gives 01, 110 (0–20 mA) gives 10 and 111 (0–24 mA) gives 11. Any other code gives ispan_o 00.
  - vout_en_o is the output-enable bit AND a voltage code. iout_en_o is the output-enable bit AND a current code.
- R3: A control write whose range field is 100 changes none of the stored control fields and does not touch data_o.
- R4: An accepted control write whose range differs from the stored one makes data_o, one cycle later, equal to a clear code:
  - 0x8000 for the bipolar codes 010 and 011;
  - otherwise 0xFFFF when the written clear-select bit is 1, and 0x0000 when it is 0.
- R5: When a range-changing control write and a data write occur in the same cycle, the clear code is loaded and the data word is discarded.
- R6: A data write without a range change loads data_i into data_o one cycle later. A control write that repeats the stored range code leaves data_o unchanged.
- R7: ovr_act_o is high only when the overrange bit is set and the voltage output is enabled. It has no effect on current ranges or on data_o.
- R8: In dual-output mode (dual bit 1):
  - vout_en_o is high for range codes 000–011 and low for 101–111, whatever the output-enable bit is;
  - ispan_o equals the current-range field (00 disabled, 01 4–20 mA, 10 0–20 mA, 11 0–24 mA);
  - iout_en_o is high when that field is non-zero.
- R9: In single-output mode vout_en_o and iout_en_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_range_i | input | 3 | Range code |
| ctrl_ovr_i | input | 1 | Voltage overrange (+10%) request |
| ctrl_clr_sel_i | input | 1 | Clear code select |
| ctrl_out_en_i | input | 1 | Output enable for single-output mode |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_dual_i | input | 1 | Dual-output enable |
| cfg_irange_i | input | 2 | Current range in dual-output mode |
| data_we_i | input | 1 | Data word write strobe |
| data_i | input | 16 | DAC data word |
| vout_en_o | output | 1 | Voltage output enabled |
| iout_en_o | output | 1 | Current output enabled |
| vspan_o | output | 3 | Voltage span code (0 = none) |
| ispan_o | output | 2 | Current span code (0 = none) |
| ovr_act_o | output | 1 | Overrange active on voltage output |
| data_o | output | 16 | DAC data register |

## Verification
The bench runs the reserved range code against a register that already holds other settings. A design that stored the field, or that accepted the other bits of the word, would show a changed span, changed overrange or cleared data. It sends a range change and a data write in the same cycle; a design with the wrong priority outputs the data word in place of the clear code. It rewrites the current range after loading non-zero data, which exposes a clear that fires on every control write instead of only on a change. It also covers both clear-select values across unipolar, bipolar and current ranges, and switches into dual mode with the enable bit low, which catches a design that still gates the voltage output with that bit.

// File: rtl/dac_range_pkg.sv
package dac_range_pkg;
  localparam int unsigned RANGE_W  = 3;
  localparam int unsigned IRANGE_W = 2;
  localparam int unsigned VSPAN_W  = 3;
  localparam logic [RANGE_W-1:0] RANGE_RSVD = 3'b100;

  typedef struct packed {
    logic [RANGE_W-1:0] range;
    logic               ovr;
    logic               clr_sel;
    logic               out_en;
  } ctrl_t;

  typedef struct packed {
    logic                dual;
    logic [IRANGE_W-1:0] irange;
  } cfg_t;

  function automatic logic is_bipolar(logic [RANGE_W-1:0] r);
    return (r == 3'b010) || (r == 3'b011);
  endfunction
endpackage

// File: rtl/dac_range_regs.sv
module dac_range_regs
  import dac_range_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_we_i,
  input  ctrl_t ctrl_i,
  input  logic  cfg_we_i,
  input  cfg_t  cfg_i,
  output ctrl_t ctrl_o,
  output cfg_t  cfg_o,
  output logic  range_chg_o
);
  ctrl_t ctrl_q;
  cfg_t  cfg_q;
  logic  accept;

  assign accept      = ctrl_we_i && (ctrl_i.range != RANGE_RSVD);
  assign range_chg_o = accept && (ctrl_i.range != ctrl_q.range);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (accept)   ctrl_q <= ctrl_i;
      if (cfg_we_i) cfg_q  <= cfg_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cfg_o  = cfg_q;

  // R3: reserved code leaves every control field in place
  a_r3_rsvd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_i.range == RANGE_RSVD) |=> $stable(ctrl_q));

  a_r3_never_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.range != RANGE_RSVD);
endmodule

// File: rtl/dac_range_data.sv
module dac_range_data
  import dac_range_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [RANGE_W-1:0] new_range_i,
  input  logic               clr_sel_i,
  input  logic               data_we_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] CODE_FULL = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CODE_ZERO = {DATA_W{1'b0}};

  logic [DATA_W-1:0] clr_code;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    if (is_bipolar(new_range_i)) clr_code = CODE_MID;
    else if (clr_sel_i)          clr_code = CODE_FULL;
    else                         clr_code = CODE_ZERO;
  end

  // range-change clear outranks a data write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= CODE_ZERO;
    else if (clr_i)     data_q <= clr_code;
    else if (data_we_i) data_q <= data_i;
  end

  assign data_o = data_q;

  a_r4_clear_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (data_o == CODE_MID || data_o == CODE_FULL || data_o == CODE_ZERO));

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && data_we_i && is_bipolar(new_range_i)) |=> data_o == CODE_MID);

  a_r6_data_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && data_we_i) |=> data_o == $past(data_i));
endmodule

// File: rtl/dac_range_decode.sv
module dac_range_decode
  import dac_range_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_t               ctrl_i,
  input  cfg_t                cfg_i,
  output logic                vout_en_o,
  output logic                iout_en_o,
  output logic [VSPAN_W-1:0]  vspan_o,
  output logic [IRANGE_W-1:0] ispan_o,
  output logic                ovr_act_o
);
  logic volt_sel;
  logic cur_sel;

  assign volt_sel = !ctrl_i.range[2];
  assign cur_sel  = ctrl_i.range[2];

  always_comb begin
    vspan_o = volt_sel ? ({1'b0, ctrl_i.range[1:0]} + 3'd1) : '0;
    if (cfg_i.dual) begin
      ispan_o   = cfg_i.irange;
      vout_en_o = volt_sel;
      iout_en_o = (cfg_i.irange != '0);
    end else begin
      ispan_o   = cur_sel ? ctrl_i.range[1:0] : '0;
      vout_en_o = volt_sel && ctrl_i.out_en;
      iout_en_o = cur_sel && ctrl_i.out_en;
    end
  end

  assign ovr_act_o = ctrl_i.ovr && vout_en_o;

  a_r9_single_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.dual |-> !(vout_en_o && iout_en_o));

  a_r7_ovr_needs_vout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_act_o |-> vout_en_o);

  a_r8_dual_iout_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.dual && cfg_i.irange == '0) |-> !iout_en_o);

  a_r2_span_zero_when_current: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_sel |-> vspan_o == '0);
endmodule

// File: rtl/dac_range_ctrl.sv
module dac_range_ctrl
  import dac_range_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [RANGE_W-1:0]  ctrl_range_i,
  input  logic                ctrl_ovr_i,
  input  logic                ctrl_clr_sel_i,
  input  logic                ctrl_out_en_i,
  input  logic                cfg_we_i,
  input  logic                cfg_dual_i,
  input  logic [IRANGE_W-1:0] cfg_irange_i,
  input  logic                data_we_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                vout_en_o,
  output logic                iout_en_o,
  output logic [VSPAN_W-1:0]  vspan_o,
  output logic [IRANGE_W-1:0] ispan_o,
  output logic                ovr_act_o,
  output logic [DATA_W-1:0]   data_o
);
  ctrl_t ctrl_w, ctrl_q;
  cfg_t  cfg_w, cfg_q;
  logic  range_chg;

  assign ctrl_w = '{range: ctrl_range_i, ovr: ctrl_ovr_i,
                    clr_sel: ctrl_clr_sel_i, out_en: ctrl_out_en_i};
  assign cfg_w  = '{dual: cfg_dual_i, irange: cfg_irange_i};

  dac_range_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_i      (ctrl_w),
    .cfg_we_i    (cfg_we_i),
    .cfg_i       (cfg_w),
    .ctrl_o      (ctrl_q),
    .cfg_o       (cfg_q),
    .range_chg_o (range_chg)
  );

  dac_range_data #(.DATA_W(DATA_W)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (range_chg),
    .new_range_i (ctrl_range_i),
    .clr_sel_i   (ctrl_clr_sel_i),
    .data_we_i   (data_we_i),
    .data_i      (data_i),
    .data_o      (data_o)
  );

  dac_range_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_q),
    .cfg_i     (cfg_q),
    .vout_en_o (vout_en_o),
    .iout_en_o (iout_en_o),
    .vspan_o   (vspan_o),
    .ispan_o   (ispan_o),
    .ovr_act_o (ovr_act_o)
  );

  // R6: repeating the stored range never clears
  a_r6_same_range_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_range_i == ctrl_q.range && !data_we_i) |=> $stable(data_o));

  a_r3_rsvd_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_range_i == RANGE_RSVD && !data_we_i) |=> $stable(data_o));
endmodule

// File: tb/dac_range_ctrl_tb.sv
`timescale 1ns/1ps
module dac_range_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctrl_we = 0, ctrl_ovr = 0, ctrl_clr = 0, ctrl_oe = 0;
  logic [2:0]  ctrl_rng = 0;
  logic        cfg_we = 0, cfg_dual = 0;
  logic [1:0]  cfg_ir = 0;
  logic        data_we = 0;
  logic [15:0] din = 0;
  logic        vout_en, iout_en, ovr_act;
  logic [2:0]  vspan;
  logic [1:0]  ispan;
  logic [15:0] dout;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_range_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_range_i(ctrl_rng), .ctrl_ovr_i(ctrl_ovr),
    .ctrl_clr_sel_i(ctrl_clr), .ctrl_out_en_i(ctrl_oe),
    .cfg_we_i(cfg_we), .cfg_dual_i(cfg_dual), .cfg_irange_i(cfg_ir),
    .data_we_i(data_we), .data_i(din),
    .vout_en_o(vout_en), .iout_en_o(iout_en), .vspan_o(vspan),
    .ispan_o(ispan), .ovr_act_o(ovr_act), .data_o(dout)
  );

  // behavioural reference model
  int m_rng, m_ovr, m_clr, m_oe, m_dual, m_ir, m_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rng = 0; m_ovr = 0; m_clr = 0; m_oe = 0; m_dual = 0; m_ir = 0; m_data = 0;
    end else begin
      if (ctrl_we && ctrl_rng != 4 && int'(ctrl_rng) != m_rng) begin
        if (ctrl_rng == 2 || ctrl_rng == 3) m_data = 'h8000;
        else m_data = ctrl_clr ? 'hFFFF : 0;
      end else if (data_we) m_data = din;
      if (ctrl_we && ctrl_rng != 4) begin
        m_rng = ctrl_rng; m_ovr = ctrl_ovr; m_clr = ctrl_clr; m_oe = ctrl_oe;
      end
      if (cfg_we) begin m_dual = cfg_dual; m_ir = cfg_ir; end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int e_v, e_i, e_vs, e_is;
    e_vs = (m_rng < 4) ? m_rng + 1 : 0;
    if (m_dual != 0) begin
      e_is = m_ir; e_v = (m_rng < 4); e_i = (m_ir != 0);
    end else begin
      e_is = (m_rng >= 5) ? m_rng - 4 : 0;
      e_v = (m_oe != 0) && (m_rng < 4);
      e_i = (m_oe != 0) && (m_rng >= 5);
    end
    cmp("R4/R5/R6 data_o", dout, m_data);
    cmp("R2/R8 vspan_o", vspan, e_vs);
    cmp("R2/R8 ispan_o", ispan, e_is);
    cmp("R2/R8/R9 vout_en_o", vout_en, e_v);
    cmp("R2/R8/R9 iout_en_o", iout_en, e_i);
    cmp("R7 ovr_act_o", ovr_act, (m_ovr != 0) && e_v);
  end

  task automatic wr_ctrl(int r, int ovr, int clr, int oe, bit dw = 0, int d = 0);
    @(posedge clk); #1;
    ctrl_we = 1; ctrl_rng = r[2:0]; ctrl_ovr = ovr[0]; ctrl_clr = clr[0]; ctrl_oe = oe[0];
    data_we = dw; din = d[15:0];
    @(posedge clk); #1;
    ctrl_we = 0; data_we = 0;
    @(negedge clk);
  endtask

  task automatic wr_cfg(int dual, int ir);
    @(posedge clk); #1; cfg_we = 1; cfg_dual = dual[0]; cfg_ir = ir[1:0];
    @(posedge clk); #1; cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic wr_data(int d);
    @(posedge clk); #1; data_we = 1; din = d[15:0];
    @(posedge clk); #1; data_we = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset data", dout, 0);
    cmp("R1 reset vout_en", vout_en, 0);
    cmp("R1 reset iout_en", iout_en, 0);
    #1 rst_n = 1;
    wr_data('h1234);
    cmp("R6 data load", dout, 'h1234);
    wr_ctrl(0, 0, 0, 1);
    cmp("R6 same range keeps data", dout, 'h1234);
    cmp("R2 vspan 0-5V", vspan, 1);
    cmp("R2 vout_en", vout_en, 1);
    wr_ctrl(2, 0, 0, 1);
    cmp("R4 bipolar clear", dout, 'h8000);
    wr_data('hABCD);
    wr_ctrl(3, 0, 1, 1, 1, 'h5555);
    cmp("R5 clear beats data write", dout, 'h8000);
    wr_data('h0F0F);
    wr_ctrl(4, 1, 1, 0);
    cmp("R3 reserved keeps span", vspan, 4);
    cmp("R3 reserved keeps ovr", ovr_act, 0);
    cmp("R3 reserved keeps data", dout, 'h0F0F);
    cmp("R3 reserved keeps enable", vout_en, 1);
    wr_ctrl(1, 1, 1, 1);
    cmp("R4 unipolar clear sel1", dout, 'hFFFF);
    cmp("R7 ovr active", ovr_act, 1);
    wr_ctrl(5, 1, 1, 1);
    cmp("R7 ovr off for current", ovr_act, 0);
    cmp("R9 vout off", vout_en, 0);
    cmp("R2 iout_en", iout_en, 1);
    cmp("R2 ispan 4-20", ispan, 1);
    wr_ctrl(6, 0, 0, 1);
    cmp("R4 current clear sel0", dout, 0);
    cmp("R2 ispan 0-20", ispan, 2);
    wr_cfg(1, 3);
    wr_ctrl(0, 0, 0, 0);
    cmp("R8 dual vout without out_en", vout_en, 1);
    cmp("R8 dual iout", iout_en, 1);
    cmp("R8 dual ispan", ispan, 3);
    wr_ctrl(7, 0, 0, 0);
    cmp("R8 dual vout disabled", vout_en, 0);
    cmp("R8 dual vspan zero", vspan, 0);
    wr_cfg(1, 0);
    cmp("R8 dual iout disabled", iout_en, 0);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      ctrl_we = ($urandom_range(0, 3) == 0);
      ctrl_rng = 3'($urandom_range(0, 7));
      ctrl_ovr = 1'($urandom); ctrl_clr = 1'($urandom); ctrl_oe = 1'($urandom);
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_dual = 1'($urandom); cfg_ir = 2'($urandom);
      data_we = ($urandom_range(0, 2) == 0);
      din = 16'($urandom);
    end
    @(posedge clk); #1; ctrl_we = 0; cfg_we = 0; data_we = 0;
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule